// File: doc/BRIEF.md
# Multiplexed Bus Cycle Generator

This block runs one external bus machine cycle for an 8-bit processor. The processor's low address byte and its data share one 8-bit bus. A caller places a cycle kind, a 16-bit address and a write byte on the request port. The block latches them when it is idle and then steps through the T-states of the cycle.

In the first T-state an address-latch strobe marks the moment when the shared lines carry the low address byte. The high address byte sits on its own dedicated lines. From the second T-state on, the shared lines carry data. The read or write strobe is active during the second and third T-states. The three status lines identify the kind of cycle for its whole duration. Read data is captured as the strobe ends, and a one-clock completion pulse follows the last T-state.

The kind code on the request port is the status code itself, written as {io_m_n, s1, s0}. One code is invalid, and a request carrying it is dropped without producing any bus activity.

Top module: `mux_bus_cycle`

## Requirements
- R1: When the block is idle and `req_valid` is high with a valid kind, the request is latched on that clock edge. The cycle enters T1 on the next clock, and `busy` is high from T1 through the last T-state.
- R2: `ale` is high only during T1. During T1, `ad_oe` is 1, `ad_out` carries address bits [7:0] and `a_hi` carries address bits [15:8].
- R3: An opcode fetch (kind 011) and an interrupt acknowledge (kind 111) last four T-states. Memory read (010), memory write (001), I/O read (110), I/O write (101) and halt (000) last three T-states.
- R4: The status lines {io_m_n, s1, s0} equal the request's kind code from T1 to the end of the cycle. When the block is idle they keep the code of the last cycle, and they are 000 after reset.
- R5: The read kinds are 011, 010, 110 and 111. For these, `rd_n` is low and `ad_oe` is 0 in T2 and T3, and `wr_n` stays high. `rdata` takes the value of `ad_in` present during T3.
- R6: The write kinds are 001 and 101. For these, `wr_n` is low and `ad_oe` is 1 in T2 and T3, `ad_out` equals the write byte, and `rd_n` stays high.
- R7: In T4, `rd_n` and `wr_n` are high and `ad_oe` is 0.
- R8: A halt cycle (000) asserts neither strobe, and `ad_oe` is 0 after T1.
- R9: A request with kind 100 is ignored. In that case `busy`, `ale` and `done` stay low, both strobes stay high, `ad_oe` stays 0 and the status lines are unchanged.
- R10: A request presented while `busy` is high is ignored and does not change the cycle in progress.
- R11: `done` is high for exactly one clock, in the cycle right after the last T-state. At that point `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind, equal to its status code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| ad_in | input | 8 | Shared bus value sampled from the pins |
| ad_out | output | 8 | Shared bus value driven to the pins |
| ad_oe | output | 1 | Shared bus output enable |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m_n | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Cycle in progress |

## Verification
The hardest situation to reach is a request that arrives while a cycle is running, especially a request whose new fields differ from the latched ones. The bench keeps `req_valid` high into T2 with a different kind, address and byte, then checks that the running cycle still shows its original values. It also checks that no second cycle starts afterwards. Random kinds, addresses and bytes are mixed with directed halt and invalid-code requests, and each T-state is checked against values computed from the kind.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } tstate_e;

    localparam logic [2:0] CODE_HALT = 3'b000;
    localparam logic [2:0] CODE_MWR  = 3'b001;
    localparam logic [2:0] CODE_MRD  = 3'b010;
    localparam logic [2:0] CODE_OPF  = 3'b011;
    localparam logic [2:0] CODE_BAD  = 3'b100;
    localparam logic [2:0] CODE_IOWR = 3'b101;
    localparam logic [2:0] CODE_IORD = 3'b110;
    localparam logic [2:0] CODE_INTA = 3'b111;

    typedef struct packed {
        logic ok;
        logic rd;
        logic wr;
        logic long_c;
    } kind_attr_t;
endpackage

// File: rtl/mbc_decode.sv
module mbc_decode
    import mbc_pkg::*;
(
    input  logic [2:0]  code,
    output kind_attr_t  attr
);
    always_comb begin
        attr = '0;
        unique case (code)
            CODE_HALT: attr = '{ok: 1'b1, rd: 1'b0, wr: 1'b0, long_c: 1'b0};
            CODE_MWR:  attr = '{ok: 1'b1, rd: 1'b0, wr: 1'b1, long_c: 1'b0};
            CODE_MRD:  attr = '{ok: 1'b1, rd: 1'b1, wr: 1'b0, long_c: 1'b0};
            CODE_OPF:  attr = '{ok: 1'b1, rd: 1'b1, wr: 1'b0, long_c: 1'b1};
            CODE_BAD:  attr = '{ok: 1'b0, rd: 1'b0, wr: 1'b0, long_c: 1'b0};
            CODE_IOWR: attr = '{ok: 1'b1, rd: 1'b0, wr: 1'b1, long_c: 1'b0};
            CODE_IORD: attr = '{ok: 1'b1, rd: 1'b1, wr: 1'b0, long_c: 1'b0};
            CODE_INTA: attr = '{ok: 1'b1, rd: 1'b1, wr: 1'b0, long_c: 1'b1};
            default:   attr = '0;
        endcase
    end
endmodule

// File: rtl/mbc_fsm.sv
module mbc_fsm
    import mbc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    long_c,
    output tstate_e st,
    output logic    last,
    output logic    done
);
    tstate_e st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_T1;
            ST_T1:   st_nx = ST_T2;
            ST_T2:   st_nx = ST_T3;
            ST_T3:   st_nx = long_c ? ST_T4 : ST_IDLE;
            ST_T4:   st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    assign last = (st == ST_T4) || ((st == ST_T3) && !long_c);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st   <= st_nx;
            done <= last;
        end
    end
endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [2:0]        in_code,
    input  kind_attr_t        in_attr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [2:0]        code_q,
    output kind_attr_t        attr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            attr_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                code_q  <= in_code;
                attr_q  <= in_attr;
                addr_q  <= in_addr;
                wdata_q <= in_wdata;
            end
            if (capture) rdata_q <= bus_in;
        end
    end
endmodule

// File: rtl/mux_bus_cycle.sv
module mux_bus_cycle
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m_n,
    output logic                     s1,
    output logic                     s0,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done,
    output logic                     busy
);
    localparam int HI_W = ADDR_W - DATA_W;

    kind_attr_t        dec_attr;
    kind_attr_t        attr_q;
    tstate_e           st;
    logic              last;
    logic              accept;
    logic              capture;
    logic [2:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    mbc_decode u_dec (
        .code (req_kind),
        .attr (dec_attr)
    );

    assign accept  = req_valid && (st == ST_IDLE) && dec_attr.ok;
    assign capture = (st == ST_T3) && attr_q.rd;

    mbc_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .long_c (attr_q.long_c),
        .st     (st),
        .last   (last),
        .done   (done)
    );

    mbc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_code  (req_kind),
        .in_attr  (dec_attr),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .capture  (capture),
        .bus_in   (ad_in),
        .code_q   (code_q),
        .attr_q   (attr_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata)
    );

    assign {io_m_n, s1, s0} = code_q;
    assign a_hi             = addr_q[ADDR_W-1 -: HI_W];

    always_comb begin
        ale    = 1'b0;
        ad_oe  = 1'b0;
        ad_out = '0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        busy   = 1'b1;
        unique case (st)
            ST_IDLE: busy = 1'b0;
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_q[DATA_W-1:0];
            end
            ST_T2, ST_T3: begin
                rd_n   = !attr_q.rd;
                wr_n   = !attr_q.wr;
                ad_oe  = attr_q.wr;
                ad_out = attr_q.wr ? wdata_q : '0;
            end
            ST_T4: begin
                ad_oe = 1'b0;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       ad_oe,
    input logic       rd_n,
    input logic       wr_n,
    input logic [2:0] status,
    input logic       busy,
    input logic       done
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2
    AST_ALE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> busy); // R2
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> $stable(status)); // R4
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R5
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && rd_n)); // R6
    AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status != 3'b100)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
endmodule

bind mux_bus_cycle mbc_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .ad_oe  (ad_oe),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .status ({io_m_n, s1, s0}),
    .busy   (busy),
    .done   (done)
);

// File: tb/mux_bus_cycle_test.sv
module mux_bus_cycle_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out, rdata, a_hi;
    logic        ad_oe, ale, rd_n, wr_n, io_m_n, s1, s0, done, busy;

    int tests = 0;
    int fails = 0;
    logic [2:0] last_code = 3'b000;

    always #5 clk = ~clk;

    mux_bus_cycle uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_m_n(io_m_n), .s1(s1), .s0(s0),
        .rdata(rdata), .done(done), .busy(busy)
    );

    function automatic int exp_len(input logic [2:0] k);
        return (k == 3'b011 || k == 3'b111) ? 4 : 3;
    endfunction
    function automatic bit exp_rd(input logic [2:0] k);
        return k == 3'b011 || k == 3'b010 || k == 3'b110 || k == 3'b111;
    endfunction
    function automatic bit exp_wr(input logic [2:0] k);
        return k == 3'b001 || k == 3'b101;
    endfunction
    function automatic logic [2:0] pick_kind(input int n);
        case (n)
            0: return 3'b000; 1: return 3'b001; 2: return 3'b010;
            3: return 3'b011; 4: return 3'b101; 5: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rv, input bit poke);
        int n;
        n = exp_len(k);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        @(negedge clk);
        if (poke) begin
            req_kind = (k == 3'b001) ? 3'b010 : 3'b001;
            req_addr = ~a; req_wdata = ~wd;
        end else req_valid = 1'b0;
        chk(busy == 1'b1, "R1 busy in T1", busy, 1);
        chk(ale == 1'b1 && ad_oe == 1'b1, "R2 ale/oe in T1", {ale, ad_oe}, 3);
        chk(ad_out == a[7:0], "R2 low address", ad_out, a[7:0]);
        chk(a_hi == a[15:8], "R2 high address", a_hi, a[15:8]);
        chk({io_m_n, s1, s0} == k, "R4 status T1", {io_m_n, s1, s0}, k);
        for (int t = 2; t <= n; t++) begin
            @(negedge clk);
            if (t == 3) begin
                req_valid = 1'b0;
                ad_in = rv;
            end
            chk(ale == 1'b0 && busy == 1'b1, "R2 ale low/busy", {ale, busy}, 1);
            chk({io_m_n, s1, s0} == k, "R4 status held", {io_m_n, s1, s0}, k);
            if (t <= 3) begin
                chk(rd_n == !exp_rd(k), "R5 rd_n", rd_n, !exp_rd(k));
                chk(wr_n == !exp_wr(k), "R6 wr_n", wr_n, !exp_wr(k));
                chk(ad_oe == exp_wr(k), "R5 R6 R8 bus enable", ad_oe, exp_wr(k));
                if (exp_wr(k)) chk(ad_out == wd, "R6 write data", ad_out, wd);
                if (poke) chk(a_hi == a[15:8], "R10 address kept", a_hi, a[15:8]);
            end else begin
                chk(rd_n && wr_n && !ad_oe, "R7 T4 quiet", {rd_n, wr_n, ad_oe}, 6);
            end
        end
        @(negedge clk);
        ad_in = 8'($urandom);
        chk(done == 1'b1 && busy == 1'b0, "R3 R11 done after last T", {done, busy}, 2);
        if (exp_rd(k)) chk(rdata == rv, "R5 read capture", rdata, rv);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 R11 single pulse, no restart", {done, busy}, 0);
        last_code = k;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(busy == 0 && ale == 0 && done == 0 && ad_oe == 0, "R1 reset idle",
            {busy, ale, done, ad_oe}, 0);
        chk(rd_n && wr_n, "R5 reset strobes", {rd_n, wr_n}, 3);
        chk({io_m_n, s1, s0} == 3'b000, "R4 reset status", {io_m_n, s1, s0}, 0);
        rst_n = 1'b1;

        run_cycle(3'b011, 16'h2001, 8'h00, 8'hC6, 1'b0);
        run_cycle(3'b010, 16'h2002, 8'h00, 8'h56, 1'b0);
        run_cycle(3'b001, 16'h42A5, 8'h3C, 8'h00, 1'b0);
        run_cycle(3'b000, 16'hFFFF, 8'h11, 8'h99, 1'b0);
        run_cycle(3'b111, 16'h0038, 8'h00, 8'hFF, 1'b0);
        run_cycle(3'b110, 16'h8080, 8'h00, 8'h5A, 1'b1);
        run_cycle(3'b101, 16'h1234, 8'hA5, 8'h00, 1'b1);

        // R9 invalid kind
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'b100; req_addr = 16'hBEEF; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(busy == 0 && ale == 0 && done == 0 && ad_oe == 0, "R9 invalid ignored",
                {busy, ale, done, ad_oe}, 0);
            chk(rd_n && wr_n, "R9 strobes idle", {rd_n, wr_n}, 3);
            chk({io_m_n, s1, s0} == last_code, "R9 status unchanged",
                {io_m_n, s1, s0}, last_code);
            @(negedge clk);
        end

        for (int i = 0; i < 40; i++) begin
            run_cycle(pick_kind(int'($urandom % 7)), 16'($urandom), 8'($urandom),
                      8'($urandom), ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule